// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the already synchronised inputs of one GPIO bank and turns pin activity into interrupt requests. Each pin has its own detection mode, chosen by three configuration bits: a type bit (level or edge), a polarity bit and an any-edge bit. The available modes are active-high level, active-low level, rising edge, falling edge and both edges. Any detected event sets a sticky status bit. Software clears a status bit by writing a one to it.

A mask register gates which status bits reach the single interrupt output. Software never writes the mask directly. One write-only register clears mask bits wherever a one is written, and a second write-only register sets mask bits the same way. Detection runs all the time, whatever the mask says. A masked pin therefore still records its events, and they show up on the interrupt output as soon as the pin is unmasked.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held and right after it, mask reads as all ones, status reads as zero, the type, polarity and any-edge registers read as zero, and irq is low.
- R2: A pin whose type bit is 0 uses level detection. Polarity 1 sets status on every cycle the pin is high. Polarity 0 sets status on every cycle the pin is low. The any-edge bit has no effect in this mode.
- R3: A pin whose type bit is 1 and any-edge bit is 0 uses edge detection. An edge is found by comparing the current input with its value from the previous cycle. Polarity 1 sets status on a 0-to-1 change. Polarity 0 sets status on a 1-to-0 change.
- R4: A pin whose type bit is 1 and any-edge bit is 1 sets status on either kind of change, whatever its polarity bit.
- R5: A status bit stays set until it is cleared. Writing the status register (select 3) clears each bit written as 1 and leaves bits written as 0 untouched.
- R6: If a status bit of a level-mode pin is cleared while its active level is still present, the bit still reads as set afterwards.
- R7: If a status clear and a new detection land on the same bit in the same cycle, the bit stays set.
- R8: Writing select 1 clears the mask bits written as 1. Writing select 2 sets the mask bits written as 1. Bits written as 0 leave the mask unchanged in both cases. The mask reads at select 0.
- R9: Status bits are set by detection whether or not the pin is masked.
- R10: irq is high exactly when some status bit is set and its mask bit is 0.
- R11: Register selects are: 0 mask, 1 unmask, 2 mask-set, 3 status, 4 type, 5 polarity, 6 any-edge. Selects 1, 2 and 7 read as zero. Selects 4 to 6 read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | W | Synchronised pin levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every detection mode, including the combinations where the polarity or any-edge bit should be ignored, on pins at both ends and in the middle of the bank. For each one it steps through input changes while tracking the expected sticky status. A design that tied the edge reference to the wrong cycle, or that honoured polarity in both-edge mode, would set the wrong status bits.

The bench also checks the irq output while the pin is masked. A design that stopped detection while masked would show a clear status at that point, and one that forgot to gate the output would raise irq.

Three cases go after the clear logic:
- a clear that lands in the same cycle as a new edge, which a wrong priority loses;
- a clear while a level is still active, which must leave the bit set;
- zero bits in clear, unmask and mask-set writes, which a design that treats the write as a plain store would corrupt.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam logic [2:0] SEL_MASK = 3'd0;
  localparam logic [2:0] SEL_UNMASK = 3'd1;
  localparam logic [2:0] SEL_MASKSET = 3'd2;
  localparam logic [2:0] SEL_STAT = 3'd3;
  localparam logic [2:0] SEL_TYPE = 3'd4;
  localparam logic [2:0] SEL_POL = 3'd5;
  localparam logic [2:0] SEL_ANY = 3'd6;

  logic [W-1:0] typ_q, pol_q, any_q, mask_q, stat_q, prev_q;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;

  assign rise     = pin_in & ~prev_q;
  assign fall     = ~pin_in & prev_q;
  assign edge_hit = (any_q & (rise | fall)) | (~any_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = (pol_q & pin_in) | (~pol_q & ~pin_in);
  assign hit      = (typ_q & edge_hit) | (~typ_q & lvl_hit);
  assign clr      = (wr_en && addr == SEL_STAT) ? wdata : '0;
  assign irq      = |(stat_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q  <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_in;
      stat_q <= (stat_q & ~clr) | hit;
      if (wr_en) begin
        case (addr)
          SEL_UNMASK:  mask_q <= mask_q & ~wdata;
          SEL_MASKSET: mask_q <= mask_q | wdata;
          SEL_TYPE:    typ_q  <= wdata;
          SEL_POL:     pol_q  <= wdata;
          SEL_ANY:     any_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      SEL_MASK: rdata = mask_q;
      SEL_STAT: rdata = stat_q;
      SEL_TYPE: rdata = typ_q;
      SEL_POL:  rdata = pol_q;
      SEL_ANY:  rdata = any_q;
      default:  rdata = '0;
    endcase
  end
endmodule

module gpio_irq_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] stat_q,
  input logic         irq
);
  // R8
  unmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> ((mask_q & $past(wdata)) == '0));
  // R8
  maskset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == 3'd1 || addr == 3'd2)) |=> $stable(mask_q));
  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd3) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [W-1:0] pin_in = '1, wdata = '0, rdata;
  logic [2:0] addr = 3'd0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_unit #(.W(W)) i_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic setpin(int p, logic v);
    @(negedge clk); pin_in[p] = v;
  endtask

  function automatic logic hitf(logic t, logic p, logic a, logic pv, logic cv);
    if (!t) return p ? cv : !cv;
    if (a) return pv ^ cv;
    return p ? (!pv && cv) : (pv && !cv);
  endfunction

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] d, st;
    int pins[4] = '{0, 5, 17, 31};
    logic [2:0] cfg[7] = '{3'b010, 3'b000, 3'b011, 3'b110, 3'b100, 3'b101, 3'b111};
    string tag[7] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4"};

    repeat (2) @(negedge clk);
    addr = 3'd0; #1 check("R1 mask", rdata, '1);
    addr = 3'd3; #1 check("R1 status", rdata, '0);
    check("R1 irq", {31'd0, irq}, '0);
    rst_n = 1;
    rd(3'd4, d); check("R1 type", d, '0);
    rd(3'd5, d); check("R1 pol", d, '0);
    rd(3'd6, d); check("R1 any", d, '0);
    rd(3'd3, d); check("R1 status idle", d, '0);

    wr(3'd4, 32'hA5A5_0F0F); rd(3'd4, d); check("R11 type rb", d, 32'hA5A5_0F0F);
    wr(3'd5, 32'h1234_5678); rd(3'd5, d); check("R11 pol rb", d, 32'h1234_5678);
    wr(3'd6, 32'h0BAD_F00D); rd(3'd6, d); check("R11 any rb", d, 32'h0BAD_F00D);
    rd(3'd1, d); check("R11 sel1 zero", d, '0);
    rd(3'd2, d); check("R11 sel2 zero", d, '0);
    rd(3'd7, d); check("R11 sel7 zero", d, '0);

    foreach (pins[i]) begin
      for (int m = 0; m < 7; m++) begin
        int p = pins[i];
        logic t = cfg[m][2], po = cfg[m][1], a = cfg[m][0];
        wr(3'd4, W'(t) << p);
        wr(3'd5, W'(po) << p);
        wr(3'd6, W'(a) << p);
        wr(3'd3, '1);
        st = {31'd0, hitf(t, po, a, 1, 1)};
        rd(3'd3, d); check({tag[m], " after clear"}, d, st << p);
        setpin(p, 0); st[0] |= hitf(t, po, a, 1, 0);
        rd(3'd3, d); check({tag[m], " drive low"}, d, st << p);
        st[0] |= hitf(t, po, a, 0, 0);
        rd(3'd3, d); check({tag[m], " hold low"}, d, st << p);
        setpin(p, 1); st[0] |= hitf(t, po, a, 0, 1);
        rd(3'd3, d); check({tag[m], " drive high"}, d, st << p);
        check("R9 masked irq low", {31'd0, irq}, '0);
        wr(3'd1, W'(1) << p);
        @(negedge clk); check("R10 unmasked irq", {31'd0, irq}, st);
        wr(3'd2, W'(1) << p);
        @(negedge clk); check("R10 remasked irq", {31'd0, irq}, '0);
        wr(3'd3, W'(1) << p);
        rd(3'd3, d); check("R6 clear with level", d, W'(hitf(t, po, a, 1, 1)) << p);
      end
    end

    wr(3'd4, 32'h0000_0080); wr(3'd5, 32'h0000_0080); wr(3'd6, '0);
    setpin(7, 0); wr(3'd3, '1);
    rd(3'd3, d); check("R7 pre clear", d, '0);
    @(negedge clk); pin_in[7] = 1; wr_en = 1; addr = 3'd3; wdata = 32'h0000_0080;
    @(negedge clk); wr_en = 0; #1 check("R7 clear vs edge", rdata, 32'h0000_0080);

    wr(3'd4, 32'h0000_0014); wr(3'd5, 32'h0000_0014);
    setpin(2, 0); setpin(4, 0); wr(3'd3, '1);
    setpin(2, 1); setpin(4, 1);
    rd(3'd3, d); check("R5 two edges", d, 32'h0000_0014);
    wr(3'd3, 32'h0000_0004); rd(3'd3, d); check("R5 partial clear", d, 32'h0000_0010);
    wr(3'd3, '0); rd(3'd3, d); check("R5 zero write", d, 32'h0000_0010);

    wr(3'd1, 32'h0000_0208); rd(3'd0, d); check("R8 unmask", d, ~32'h0000_0208);
    wr(3'd2, 32'h0000_0200); rd(3'd0, d); check("R8 mask-set keeps others", d, ~32'h0000_0008);
    wr(3'd1, '0); rd(3'd0, d); check("R8 zero unmask", d, ~32'h0000_0008);
    wr(3'd1, 32'h0000_0010);
    @(negedge clk); check("R10 irq from pin4", {31'd0, irq}, 32'd1);
    wr(3'd2, '1);
    @(negedge clk); check("R10 all masked", {31'd0, irq}, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule